// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects interrupt events from external pins, a group of monitored port pins and a set of peripheral event pulses, and presents a single vectored request to a processor core. Every source owns a sticky event flag, an enable bit and a priority bit. A small write port lets software clear flags, load the enable, priority and edge-polarity masks, and set the global controls. The current flags and the two global enables are visible as outputs so that software can poll them.

A mode bit picks the scheme. In flat mode every accepted request goes to one vector, a single global enable gates all sources and a second bit also gates the peripheral class. In two-level mode each source is high or low priority with its own vector and global enable, and a high-priority request may interrupt a low-priority handler. On entry the controller clears the global enable of the accepted level. On return it sets that enable again and goes back to the level it interrupted, using a two-entry level record.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request is low, all flags are 0, the in-service level is 0 (none), both global enables are 0 and the flat mode is selected.
- R2: Each external pin has a polarity bit (1 = rising, 0 = falling; write address 3, bit i for pin i). A matching edge, after a two-stage synchronizer, sets flag bit i. An edge of the other direction sets nothing.
- R3: When any monitored port pin changes value, the port-change flag (bit NEXT, which is bit 3 by default) is set. Steady port pins set nothing.
- R4: A peripheral pulse on input k sets flag bit NEXT+1+k. Flags are sticky until software writes 1 to them at address 0. If an event and a clear hit the same flag in the same cycle, the flag stays set.
- R5: In flat mode (control register at address 4: bit0 = mode, bit1 = high/global enable, bit2 = low enable / peripheral enable), a request is raised when the global enable is 1 and some flag is set with its enable (address 1) also set. Peripheral-class sources also need bit2. The vector is 0x0008.
- R6: In two-level mode (mode = 1), a pending source whose priority bit (address 2) is 1 requests vector 0x0008, and one whose priority bit is 0 requests 0x0018. Pin 0 is always high priority, whatever its priority bit.
- R7: In two-level mode, a high-priority request needs only the high enable. A low-priority request needs both the high and the low enable.
- R8: An acknowledge while a request is up clears the enable of the accepted level (high enable for 0x0008, low enable for 0x0018). It sets the in-service level to 2 (high) or 1 (low).
- R9: A high-priority request preempts a low-level handler (level becomes 2). A low-priority request is never raised while the level is 2.
- R10: A return sets the enable of the current level again and restores the level that was interrupted, so two returns after a preemption give level 1 and then level 0.
- R11: A flag left set is requested again as soon as its level's enable is restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_pin | input | NEXT | External interrupt pins (asynchronous) |
| port_pin | input | NPORT | Monitored port pins (asynchronous) |
| periph_evt | input | NPERIPH | Peripheral event pulses (synchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 clear, 1 enable, 2 priority, 3 polarity, 4 control |
| wr_data | input | NSRC | Write data |
| irq_ack | input | 1 | Core enters the handler |
| irq_ret | input | 1 | Core returns from the handler |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | ADDR_W | Vector address for the request |
| in_svc | output | 2 | In-service level: 0 none, 1 low, 2 high |
| flags_o | output | NSRC | Current event flags |
| glb_hi_o | output | 1 | High (flat: global) enable |
| glb_lo_o | output | 1 | Low (flat: peripheral) enable |

## Verification
The hardest state to reach is a preempted low-level handler that is then unwound. To get there, the stimulus takes a low-priority peripheral event into its handler, raises pin 0 while the low enable is still clear, acknowledges the high request, and then issues two returns. After each return the level and both enables are checked. The reverse order is also covered: a low event arriving inside a high handler must stay silent until the return, and is then requested at once.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {
      LV_NONE = 2'd0,
      LV_LOW  = 2'd1,
      LV_HIGH = 2'd2
   } lvl_e;

   localparam logic [2:0] RA_CLEAR = 3'd0;
   localparam logic [2:0] RA_ENA   = 3'd1;
   localparam logic [2:0] RA_PRIO  = 3'd2;
   localparam logic [2:0] RA_POL   = 3'd3;
   localparam logic [2:0] RA_CTRL  = 3'd4;

   localparam int CB_MODE = 0;
   localparam int CB_GHI  = 1;
   localparam int CB_GLO  = 2;
endpackage

// File: rtl/irqc_sync_hist.sv
module irqc_sync_hist #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] cur,
   output logic [W-1:0] prv
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv <= '0;
      else        prv <= stg[STAGES-1];
   end

   assign cur = stg[STAGES-1];
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags #(
   parameter int NEXT        = 3,
   parameter int NPORT       = 4,
   parameter int NPERIPH     = 8,
   parameter int SYNC_STAGES = 2,
   localparam int NSRC       = NEXT + 1 + NPERIPH
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NEXT-1:0]    ext_pin,
   input  logic [NPORT-1:0]   port_pin,
   input  logic [NPERIPH-1:0] periph_evt,
   input  logic [NEXT-1:0]    pol,
   input  logic [NSRC-1:0]    clr,
   output logic [NSRC-1:0]    flags
);
   logic [NEXT-1:0]  ext_cur, ext_prv, ext_hit;
   logic [NPORT-1:0] prt_cur, prt_prv;
   logic             prt_chg;
   logic [NSRC-1:0]  set_v;

   irqc_sync_hist #(.W(NEXT), .STAGES(SYNC_STAGES)) u_ext (
      .clk(clk), .rst_n(rst_n), .din(ext_pin), .cur(ext_cur), .prv(ext_prv));

   irqc_sync_hist #(.W(NPORT), .STAGES(SYNC_STAGES)) u_prt (
      .clk(clk), .rst_n(rst_n), .din(port_pin), .cur(prt_cur), .prv(prt_prv));

   for (genvar i = 0; i < NEXT; i++) begin : g_edge
      assign ext_hit[i] = pol[i] ? (ext_cur[i] & ~ext_prv[i])
                                 : (~ext_cur[i] & ext_prv[i]);
   end

   assign prt_chg = |(prt_cur ^ prt_prv);
   assign set_v   = {periph_evt, prt_chg, ext_hit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr) | set_v;
   end
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve #(
   parameter int NEXT    = 3,
   parameter int NPERIPH = 8,
   parameter int ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] VEC_HI = 16'h0008,
   parameter logic [ADDR_W-1:0] VEC_LO = 16'h0018,
   localparam int NSRC   = NEXT + 1 + NPERIPH,
   localparam int NCORE  = NEXT + 1
) (
   input  logic [NSRC-1:0]   flags,
   input  logic [NSRC-1:0]   ena,
   input  logic [NSRC-1:1]   prio,
   input  logic              two_lvl,
   input  logic              g_hi,
   input  logic              g_lo,
   output logic              req,
   output logic              take_hi,
   output logic [ADDR_W-1:0] vec
);
   localparam logic [NSRC-1:0] CORE_M = {{NPERIPH{1'b0}}, {NCORE{1'b1}}};

   logic [NSRC-1:0] pend, hi_m;
   logic            flat_req, hi_req, lo_req;

   assign pend     = flags & ena;
   assign hi_m     = {prio, 1'b1};
   assign flat_req = g_hi & |(pend & (CORE_M | (g_lo ? ~CORE_M : '0)));
   assign hi_req   = g_hi & |(pend & hi_m);
   assign lo_req   = g_hi & g_lo & |(pend & ~hi_m);

   always_comb begin
      if (two_lvl) begin
         req     = hi_req | lo_req;
         take_hi = hi_req;
      end else begin
         req     = flat_req;
         take_hi = 1'b1;
      end
      vec = take_hi ? VEC_HI : VEC_LO;
   end
endmodule

// File: rtl/irqc_level.sv
module irqc_level
   import irqc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sw_wr,
   input  logic sw_hi,
   input  logic sw_lo,
   input  logic req,
   input  logic take_hi,
   input  logic ack,
   input  logic ret,
   output logic g_hi,
   output logic g_lo,
   output lvl_e cur
);
   lvl_e prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         g_hi <= 1'b0;
         g_lo <= 1'b0;
         cur  <= LV_NONE;
         prev <= LV_NONE;
      end else begin
         if (sw_wr) begin
            g_hi <= sw_hi;
            g_lo <= sw_lo;
         end
         if (ret && cur != LV_NONE) begin
            if (cur == LV_HIGH) g_hi <= 1'b1;
            else                g_lo <= 1'b1;
            cur  <= prev;
            prev <= LV_NONE;
         end else if (ack && req) begin
            prev <= cur;
            if (take_hi) begin
               cur  <= LV_HIGH;
               g_hi <= 1'b0;
            end else begin
               cur  <= LV_LOW;
               g_lo <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int NEXT        = 3,
   parameter int NPORT       = 4,
   parameter int NPERIPH     = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_PRIO    = 1'b1,
   parameter int ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] VEC_HI = 16'h0008,
   parameter logic [ADDR_W-1:0] VEC_LO = 16'h0018,
   localparam int NSRC       = NEXT + 1 + NPERIPH
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NEXT-1:0]    ext_pin,
   input  logic [NPORT-1:0]   port_pin,
   input  logic [NPERIPH-1:0] periph_evt,
   input  logic               wr_en,
   input  logic [2:0]         wr_addr,
   input  logic [NSRC-1:0]    wr_data,
   input  logic               irq_ack,
   input  logic               irq_ret,
   output logic               irq_req,
   output logic [ADDR_W-1:0]  irq_vec,
   output logic [1:0]         in_svc,
   output logic [NSRC-1:0]    flags_o,
   output logic               glb_hi_o,
   output logic               glb_lo_o
);
   if (NEXT < 1)        begin : g_bad_next  $error("NEXT must be at least 1");      end
   if (NPORT < 1)       begin : g_bad_port  $error("NPORT must be at least 1");     end
   if (NSRC < 3)        begin : g_bad_nsrc  $error("need at least 3 sources");      end
   if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be >= 2");     end
   if (ADDR_W < 5)      begin : g_bad_addr  $error("ADDR_W too small for vectors"); end

   logic [NSRC-1:0] ena_q;
   logic [NSRC-1:1] prio_q;
   logic [NEXT-1:0] pol_q;
   logic            mode_q, mode_eff;
   logic [NSRC-1:0] clr_v;
   logic            ctrl_wr, take_hi;
   lvl_e            lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q  <= '0;
         prio_q <= '0;
         pol_q  <= '0;
         mode_q <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            RA_ENA:  ena_q  <= wr_data;
            RA_PRIO: prio_q <= wr_data[NSRC-1:1];
            RA_POL:  pol_q  <= wr_data[NEXT-1:0];
            RA_CTRL: mode_q <= wr_data[CB_MODE];
            default: ;
         endcase
      end
   end

   if (HAS_PRIO) begin : g_two_lvl
      assign mode_eff = mode_q;
   end else begin : g_flat_only
      assign mode_eff = 1'b0;
   end

   assign clr_v   = (wr_en && wr_addr == RA_CLEAR) ? wr_data : '0;
   assign ctrl_wr = wr_en && wr_addr == RA_CTRL;

   irqc_flags #(.NEXT(NEXT), .NPORT(NPORT), .NPERIPH(NPERIPH),
                .SYNC_STAGES(SYNC_STAGES)) u_flags (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_pin(port_pin),
      .periph_evt(periph_evt), .pol(pol_q), .clr(clr_v), .flags(flags_o));

   irqc_resolve #(.NEXT(NEXT), .NPERIPH(NPERIPH), .ADDR_W(ADDR_W),
                  .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)) u_res (
      .flags(flags_o), .ena(ena_q), .prio(prio_q), .two_lvl(mode_eff),
      .g_hi(glb_hi_o), .g_lo(glb_lo_o), .req(irq_req), .take_hi(take_hi),
      .vec(irq_vec));

   irqc_level u_lvl (
      .clk(clk), .rst_n(rst_n), .sw_wr(ctrl_wr),
      .sw_hi(wr_data[CB_GHI]), .sw_lo(wr_data[CB_GLO]),
      .req(irq_req), .take_hi(take_hi), .ack(irq_ack), .ret(irq_ret),
      .g_hi(glb_hi_o), .g_lo(glb_lo_o), .cur(lvl));

   assign in_svc = lvl;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int NSRC   = 12,
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] VEC_HI = 16'h0008,
   parameter logic [ADDR_W-1:0] VEC_LO = 16'h0018
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_req,
   input logic [ADDR_W-1:0] irq_vec,
   input logic              irq_ack,
   input logic              irq_ret,
   input logic [1:0]        in_svc,
   input logic [NSRC-1:0]   flags_o,
   input logic              glb_hi_o,
   input logic              glb_lo_o,
   input logic              wr_en,
   input logic [2:0]        wr_addr,
   input logic              mode_q
);
   a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == 3'd0) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

   a_r5_req_needs_high_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> glb_hi_o);

   a_r5_flat_single_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !mode_q) |-> irq_vec == VEC_HI);

   a_r7_low_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_vec == VEC_LO) |-> (glb_hi_o && glb_lo_o));

   a_r8_high_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack && !irq_ret && irq_vec == VEC_HI) |=> (!glb_hi_o && in_svc == 2'd2));

   a_r8_low_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack && !irq_ret && irq_vec == VEC_LO) |=> (!glb_lo_o && in_svc == 2'd1));

   a_r9_no_low_in_high: assert property (@(posedge clk) disable iff (!rst_n)
      in_svc == 2'd2 |-> !(irq_req && irq_vec == VEC_LO));

   a_r10_high_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && in_svc == 2'd2) |=> glb_hi_o);

   a_r10_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
      in_svc != 2'd3);
endmodule

bind prio_irq_ctrl irqc_checker #(
   .NSRC(NSRC), .ADDR_W(ADDR_W), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
   .irq_ack(irq_ack), .irq_ret(irq_ret), .in_svc(in_svc), .flags_o(flags_o),
   .glb_hi_o(glb_hi_o), .glb_lo_o(glb_lo_o), .wr_en(wr_en), .wr_addr(wr_addr),
   .mode_q(mode_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
   localparam int NEXT = 3, NPORT = 4, NPERIPH = 8;
   localparam int NSRC = NEXT + 1 + NPERIPH;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NEXT-1:0]    ext_pin = '0;
   logic [NPORT-1:0]   port_pin = '0;
   logic [NPERIPH-1:0] periph_evt = '0;
   logic               wr_en = 1'b0;
   logic [2:0]         wr_addr = '0;
   logic [NSRC-1:0]    wr_data = '0;
   logic               irq_ack = 1'b0, irq_ret = 1'b0;
   logic               irq_req;
   logic [15:0]        irq_vec;
   logic [1:0]         in_svc;
   logic [NSRC-1:0]    flags_o;
   logic               glb_hi_o, glb_lo_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   prio_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_pin(port_pin),
      .periph_evt(periph_evt), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .irq_req(irq_req), .irq_vec(irq_vec), .in_svc(in_svc),
      .flags_o(flags_o), .glb_hi_o(glb_hi_o), .glb_lo_o(glb_lo_o));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [NSRC-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_periph(input int k);
      @(negedge clk);
      periph_evt[k] = 1'b1;
      @(negedge clk);
      periph_evt = '0;
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic ret();
      @(negedge clk); irq_ret = 1'b1;
      @(negedge clk); irq_ret = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 req", irq_req, 0);
      chk("R1 flags", flags_o, 0);
      chk("R1 level", in_svc, 0);
      chk("R1 globals", {glb_hi_o, glb_lo_o}, 0);
   endtask

   task automatic t_ext_edges();
      wr(3'd3, 12'h003);
      @(negedge clk); ext_pin[1] = 1'b1; settle();
      chk("R2 rising pin1", flags_o, 12'h002);
      @(negedge clk); ext_pin[2] = 1'b1; settle();
      chk("R2 rise on falling pin2 ignored", flags_o, 12'h002);
      @(negedge clk); ext_pin[2] = 1'b0; settle();
      chk("R2 falling pin2", flags_o, 12'h006);
      @(negedge clk); ext_pin[1] = 1'b0; settle();
      chk("R2 fall on rising pin1 ignored", flags_o, 12'h006);
      wr(3'd0, 12'hFFF);
      chk("R4 clear by write-one", flags_o, 12'h000);
   endtask

   task automatic t_port_change();
      @(negedge clk); port_pin[3] = 1'b1; settle();
      chk("R3 port change", flags_o, 12'h008);
      wr(3'd0, 12'h008); settle();
      chk("R3 steady port silent", flags_o, 12'h000);
      @(negedge clk); port_pin[3] = 1'b0; settle();
      chk("R3 change back", flags_o, 12'h008);
      wr(3'd0, 12'h008);
   endtask

   task automatic t_periph_sticky();
      pulse_periph(2);
      chk("R4 periph flag", flags_o, 12'h040);
      repeat (5) @(negedge clk);
      chk("R4 sticky", flags_o, 12'h040);
      @(negedge clk);
      periph_evt[2] = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 12'h040;
      @(negedge clk);
      periph_evt = '0; wr_en = 1'b0;
      chk("R4 set wins over clear", flags_o, 12'h040);
      wr(3'd0, 12'h040);
      chk("R4 cleared", flags_o, 12'h000);
   endtask

   task automatic t_flat();
      wr(3'd4, 12'h002);
      wr(3'd1, 12'h048);
      pulse_periph(2);
      chk("R5 periph needs peripheral enable", irq_req, 0);
      wr(3'd4, 12'h006);
      chk("R5 flat request", {irq_req, irq_vec}, {1'b1, 16'h0008});
      ack();
      chk("R8 flat entry", {irq_req, glb_hi_o, in_svc}, {1'b0, 1'b0, 2'd2});
      ret();
      chk("R10 flat return", {glb_hi_o, in_svc}, {1'b1, 2'd0});
      chk("R11 uncleared flag re-requests", irq_req, 1);
      wr(3'd0, 12'h040);
      chk("R5 cleared no request", irq_req, 0);
      wr(3'd4, 12'h002);
      @(negedge clk); port_pin[3] = 1'b1; settle();
      chk("R5 core source without peripheral enable", {irq_req, irq_vec}, {1'b1, 16'h0008});
      @(negedge clk); port_pin[3] = 1'b0; settle();
      wr(3'd0, 12'hFFF);
      chk("R5 idle", irq_req, 0);
   endtask

   task automatic t_preempt();
      wr(3'd3, 12'h001);
      wr(3'd2, 12'h000);
      wr(3'd1, 12'h041);
      wr(3'd4, 12'h003);
      pulse_periph(2);
      chk("R7 low blocked without low enable", irq_req, 0);
      wr(3'd4, 12'h007);
      chk("R6 low vector", {irq_req, irq_vec}, {1'b1, 16'h0018});
      ack();
      chk("R8 low entry", {irq_req, glb_hi_o, glb_lo_o, in_svc}, {1'b0, 1'b1, 1'b0, 2'd1});
      @(negedge clk); ext_pin[0] = 1'b1; settle();
      chk("R6 pin0 always high", {irq_req, irq_vec}, {1'b1, 16'h0008});
      ack();
      chk("R9 preempt", {glb_hi_o, in_svc}, {1'b0, 2'd2});
      wr(3'd0, 12'h001);
      ret();
      chk("R10 resume low", {glb_hi_o, glb_lo_o, in_svc, irq_req}, {1'b1, 1'b0, 2'd1, 1'b0});
      wr(3'd0, 12'h040);
      ret();
      chk("R10 back to none", {glb_lo_o, in_svc}, {1'b1, 2'd0});
      @(negedge clk); ext_pin[0] = 1'b0; settle();
      chk("R2 pin0 falling ignored", flags_o, 12'h000);
   endtask

   task automatic t_no_low_preempt();
      wr(3'd2, 12'h020);
      wr(3'd1, 12'h060);
      pulse_periph(1);
      chk("R6 high periph vector", {irq_req, irq_vec}, {1'b1, 16'h0008});
      ack();
      pulse_periph(2);
      chk("R9 low silent in high", {irq_req, in_svc}, {1'b0, 2'd2});
      wr(3'd0, 12'h020);
      ret();
      chk("R11 low taken after return", {irq_req, irq_vec, in_svc}, {1'b1, 16'h0018, 2'd0});
      wr(3'd0, 12'hFFF);
      chk("R7 idle", irq_req, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ext_edges();
      t_port_change();
      t_periph_sticky();
      t_flat();
      t_preempt();
      t_no_low_preempt();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule